// File: doc/BRIEF.md
# Calibrated one-second tick generator

This block derives a one-pulse-per-second strobe from a slow crystal oscillator of roughly 33.33 kHz. The oscillator arrives as a single-cycle enable in the system clock domain, so the whole block runs on one clock. A calibration word sets the number of oscillator ticks in a second. An optional fractional field adds one extra tick to some seconds, so that a crystal slightly off nominal keeps the right long-term rate.

Software, or a neighbouring time-of-day counter, programs the calibration word through a plain write strobe. Every write restarts the second from zero, so the next strobe comes one full programmed period after the write. The live tick count is visible on an output so that a reader can tell how far into the current second the counter is. The calibration write is a control input with no handshake: a write is taken in the cycle that `cal_we` is high.

Top module: `tickgen_top`

## Requirements
- R1: After reset `sec_pulse` is 0 and `tick_count` is 0. The calibration word resets to 0x198233: integer count 0x8233 (33331), fraction 9, correction enabled. The first second after reset is therefore 33331 ticks long.
- R2: Only bits 20:0 of `cal_wdata` are stored. Bits 31:21 have no effect on any output.
- R3: Bits 15:0 of the word give the integer count N. With bit 20 clear, every second is exactly N ticks long, whatever the value in bits 19:16.
- R4: An integer count of 0 means a second of 65536 ticks.
- R5: Bits 19:16 hold a 4-bit fraction F, applied when bit 20 is set. A 4-bit accumulator starts at 0 and adds F at the end of every second. When that addition carries out, the following second is N+1 ticks long. The first second after a write is always N ticks.
- R6: A write clears the tick counter, the accumulator and any pending extra tick. The next strobe follows exactly N ticks after the write, wherever the write fell inside the old second.
- R7: An oscillator tick that arrives in the same cycle as a write is not counted.
- R8: `sec_pulse` is high for exactly the one clock cycle after the edge that takes the last tick of a second. It is never high in a cycle that follows an edge with no counted tick.
- R9: `tick_count` gives the number of ticks counted in the current second. It reads 0 after a strobe and holds its value between ticks. During the extra tick of a stretched second it stays at N-1 for one more tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle enable per oscillator period |
| cal_we | input | 1 | Calibration write strobe |
| cal_wdata | input | 32 | Calibration write data; bits 20:0 used |
| sec_pulse | output | 1 | One-cycle seconds strobe |
| tick_count | output | 16 | Ticks counted in the current second |

## Verification
A corrupted tick counter appears on `tick_count` at the very next oscillator tick. It also moves the following strobe, so the length of a single second reveals it. A wrong accumulator or stretch flag is less visible. It only changes which seconds get the extra tick, and that can take up to sixteen seconds to show. For this reason the bench runs seventeen seconds for every fraction value and compares each second's length against an arithmetic model. A write that fails to clear the state shows up in the first second after the write, as a length other than N.

// File: rtl/tickgen_pkg.sv
package tickgen_pkg;
  localparam int CNT_W_DEF  = 16;
  localparam int FRAC_W_DEF = 4;
  localparam int WR_W_DEF   = 32;
  // integer 0x8233, fraction 9, correction on
  localparam logic [20:0] CAL_RESET = 21'h198233;
endpackage

// File: rtl/tickgen_cal_reg.sv
module tickgen_cal_reg #(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 4,
  parameter int WR_W   = 32,
  localparam int CAL_W = CNT_W + FRAC_W + 1,
  parameter logic [CAL_W-1:0] DEF_CAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [WR_W-1:0]   wdata,
  output logic [CNT_W-1:0]  limit,
  output logic [FRAC_W-1:0] frac,
  output logic              frac_en
);
  logic [CAL_W-1:0] word_q;
  logic unused_hi;

  generate
    if (WR_W > CAL_W) begin : g_hi
      assign unused_hi = ^wdata[WR_W-1:CAL_W];
    end else begin : g_nohi
      assign unused_hi = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  word_q <= DEF_CAL;
    else if (we) word_q <= wdata[CAL_W-1:0];
  end

  assign limit   = word_q[CNT_W-1:0];
  assign frac    = word_q[CNT_W +: FRAC_W];
  assign frac_en = word_q[CAL_W-1];
endmodule

// File: rtl/tickgen_frac_acc.sv
module tickgen_frac_acc #(
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en_frac,
  input  logic [FRAC_W-1:0] frac,
  input  logic              sec_end,
  input  logic              consume,
  output logic              stretch
);
  logic [FRAC_W-1:0] acc_q;
  logic              stretch_q;
  logic [FRAC_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, frac};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      stretch_q <= 1'b0;
    end else if (clr) begin
      acc_q     <= '0;
      stretch_q <= 1'b0;
    end else if (sec_end) begin
      if (en_frac) begin
        acc_q     <= sum[FRAC_W-1:0];
        stretch_q <= sum[FRAC_W];
      end else begin
        stretch_q <= 1'b0;
      end
    end else if (consume) begin
      stretch_q <= 1'b0;
    end
  end

  assign stretch = stretch_q;

  AST_ACC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sec_end || clr) |=> $stable(acc_q)); // R5
  AST_NO_STRETCH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_end && !en_frac && !clr) |=> !stretch_q); // R3
  AST_CLR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0 && !stretch_q)); // R6
endmodule

// File: rtl/tickgen_counter.sv
module tickgen_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  input  logic             stretch,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap,
  output logic             consume
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] nxt;
  logic             hit;

  assign nxt     = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  assign hit     = tick_en && (nxt == limit);
  assign wrap    = hit && !stretch;
  assign consume = hit && stretch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr)     cnt_q <= '0;
    else if (wrap)    cnt_q <= '0;
    else if (consume) cnt_q <= cnt_q;
    else if (tick_en) cnt_q <= nxt;
  end

  assign cnt = cnt_q;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !clr) |=> $stable(cnt_q)); // R9
  AST_CNT_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    (limit != '0) |-> (cnt_q < limit)); // R3
endmodule

// File: rtl/tickgen_top.sv
module tickgen_top #(
  parameter int CNT_W  = tickgen_pkg::CNT_W_DEF,
  parameter int FRAC_W = tickgen_pkg::FRAC_W_DEF,
  parameter int WR_W   = tickgen_pkg::WR_W_DEF,
  localparam int CAL_W = CNT_W + FRAC_W + 1,
  parameter logic [CAL_W-1:0] DEF_CAL = CAL_W'(tickgen_pkg::CAL_RESET)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_tick,
  input  logic             cal_we,
  input  logic [WR_W-1:0]  cal_wdata,
  output logic             sec_pulse,
  output logic [CNT_W-1:0] tick_count
);
  logic [CNT_W-1:0]  limit;
  logic [FRAC_W-1:0] frac;
  logic              frac_en;
  logic              tick_en;
  logic              stretch;
  logic              wrap;
  logic              consume;
  logic              pulse_q;

  // a write takes priority over a coincident tick
  assign tick_en = osc_tick && !cal_we;

  tickgen_cal_reg #(
    .CNT_W(CNT_W), .FRAC_W(FRAC_W), .WR_W(WR_W), .DEF_CAL(DEF_CAL)
  ) u_cal (
    .clk(clk), .rst_n(rst_n), .we(cal_we), .wdata(cal_wdata),
    .limit(limit), .frac(frac), .frac_en(frac_en)
  );

  tickgen_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .clr(cal_we),
    .limit(limit), .stretch(stretch),
    .cnt(tick_count), .wrap(wrap), .consume(consume)
  );

  tickgen_frac_acc #(.FRAC_W(FRAC_W)) u_frac (
    .clk(clk), .rst_n(rst_n), .clr(cal_we), .en_frac(frac_en),
    .frac(frac), .sec_end(wrap), .consume(consume), .stretch(stretch)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= wrap;
  end

  assign sec_pulse = pulse_q;

  AST_PULSE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |-> $past(osc_tick && !cal_we)); // R8
  AST_PULSE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |-> (tick_count == '0)); // R9
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cal_we |=> (tick_count == '0 && !sec_pulse)); // R6
endmodule

// File: tb/sim_tickgen_top.sv
module sim_tickgen_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osc_tick = 1'b0;
  logic        cal_we = 1'b0;
  logic [31:0] cal_wdata = '0;
  logic        sec_pulse;
  logic [15:0] tick_count;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  tickgen_top u0 (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .cal_we(cal_we),
    .cal_wdata(cal_wdata), .sec_pulse(sec_pulse), .tick_count(tick_count)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cal_write(input logic [31:0] d);
    cal_we = 1'b1;
    cal_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cal_we = 1'b0;
  endtask

  task automatic tick(output bit p, output int c);
    osc_tick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    osc_tick = 1'b0;
    p = sec_pulse;
    c = int'(tick_count);
  endtask

  task automatic idle(input int gap);
    for (int g = 0; g < gap; g++) begin
      int hold = int'(tick_count);
      @(posedge clk);
      @(negedge clk);
      check(sec_pulse == 1'b0, "R8 idle pulse", int'(sec_pulse), 0);
      check(int'(tick_count) == hold, "R9 idle hold", int'(tick_count), hold);
    end
  endtask

  // runs nsec seconds from a fresh restart; nfull is the second length for N
  task automatic run_seconds(input int nfull, input int frac, input bit en,
                             input int nsec, input int gap, input string req);
    int acc = 0;
    int s = 0;
    for (int k = 0; k < nsec; k++) begin
      int len = nfull + s;
      for (int t = 1; t <= len; t++) begin
        bit p;
        int c;
        tick(p, c);
        if (t < len) begin
          int ec = (t < nfull) ? t : nfull - 1;
          check(p == 1'b0, req, int'(p), 0);
          check(c == ec, "R9 count", c, ec);
        end else begin
          check(p == 1'b1, req, int'(p), 1);
          check(c == 0, "R9 wrap", c, 0);
        end
        idle(gap);
      end
      if (en) begin
        acc = acc + frac;
        s = (acc >= 16) ? 1 : 0;
        acc = acc % 16;
      end else begin
        s = 0;
      end
    end
  endtask

  function automatic logic [31:0] mk(input int junk, input bit en, input int f, input int n);
    return {junk[10:0], en, f[3:0], n[15:0]};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state and reset calibration
    check(sec_pulse == 1'b0, "R1 pulse", int'(sec_pulse), 0);
    check(tick_count == 16'd0, "R1 count", int'(tick_count), 0);
    run_seconds(33331, 9, 1'b1, 1, 0, "R1 default second");

    // R4 zero integer count means 65536 ticks
    cal_write(mk(0, 1'b0, 0, 0));
    run_seconds(65536, 0, 1'b0, 1, 0, "R4 zero count");

    // R5 sweep of integer counts and every fraction, R2 junk upper bits
    for (int n = 1; n <= 8; n++) begin
      for (int f = 0; f < 16; f++) begin
        cal_write(mk(11'h5a5 ^ (n * 16 + f), 1'b1, f, n));
        run_seconds(n, f, 1'b1, 17, 1, "R5 R2 fraction sweep");
      end
    end

    // R3 correction disabled: fraction ignored
    for (int n = 1; n <= 8; n++) begin
      cal_write(mk(0, 1'b0, 15, n));
      run_seconds(n, 15, 1'b0, 6, 1, "R3 integer only");
    end

    // R6 write in the middle of a second with an extra tick pending
    cal_write(mk(0, 1'b1, 8, 5));
    run_seconds(5, 8, 1'b1, 2, 0, "R6 setup");
    begin
      bit p;
      int c;
      tick(p, c);
      tick(p, c);
      check(c == 2, "R6 pre-write count", c, 2);
    end
    cal_write(mk(0, 1'b1, 8, 5));
    check(tick_count == 16'd0, "R6 cleared", int'(tick_count), 0);
    run_seconds(5, 8, 1'b1, 4, 0, "R6 restart");

    // R7 tick coincident with write is dropped
    cal_we = 1'b1;
    osc_tick = 1'b1;
    cal_wdata = mk(0, 1'b0, 0, 1);
    @(posedge clk);
    @(negedge clk);
    cal_we = 1'b0;
    osc_tick = 1'b0;
    check(sec_pulse == 1'b0, "R7 no pulse", int'(sec_pulse), 0);
    check(tick_count == 16'd0, "R7 count", int'(tick_count), 0);
    idle(2);
    run_seconds(1, 0, 1'b0, 3, 0, "R7 R8 back-to-back");
    cal_we = 1'b1;
    osc_tick = 1'b1;
    cal_wdata = mk(0, 1'b0, 0, 3);
    @(posedge clk);
    @(negedge clk);
    cal_we = 1'b0;
    osc_tick = 1'b0;
    check(tick_count == 16'd0, "R7 count n3", int'(tick_count), 0);
    run_seconds(3, 0, 1'b0, 2, 2, "R7 after write");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule